// File: doc/BRIEF.md
# Byte-wide erasable memory with EPROM-style mode control

This block is a synthesizable behavioural model of a small byte-wide, many-time-programmable memory that is controlled through EPROM-style pins. It has an active-low chip select, an active-low output gate and an active-low write strobe, as well as an address bus and separate data-in and data-out buses with an output-enable flag. Two digital flags stand in for analog conditions. `vpp_hi` means that the programming supply is raised. `a9_hv` means that a supervoltage is present on address line 9.

Each cycle, the block decodes one of seven operating modes from these pins: standby, read, output disable, byte program, chip erase, program inhibit and identifier readout. It reports the decoded mode on a 3-bit status output.

A program or erase takes effect only when both of these hold:
- the strobe had a falling edge while the block was already in that mode, and
- the strobe then stayed low for `PULSE_CYC` consecutive clock edges.

A byte program can only clear bits. Only a whole-array erase can return bits to 1.

The data path is a plain pin interface with no handshake. A read returns data combinationally from the addressed word, so the interface has no back-pressure. Inputs are sampled on the rising clock edge, and the array updates on the edge that completes a pulse.

Top module: `mtp_mem_ctrl`

## Requirements
- R1: `dq_oe` is 1 only in read mode and identifier mode, which both need `ce_n`=0 and `oe_n`=0. At all other times `dq_oe`=0 and `dq_out`=8'h00.
- R2: With `ce_n`=1 and `vpp_hi`=0, the mode is standby (code 0), whatever the levels on `oe_n`, `pgm_n` and `a9_hv`.
- R3: Read mode (code 1) applies when `ce_n`=0, `oe_n`=0, `vpp_hi`=0 and `a9_hv`=0. In read mode `dq_out` is the stored byte at `addr`. After reset, every byte reads 8'hFF.
- R4: Identifier mode (code 6) applies when `ce_n`=0, `oe_n`=0, `vpp_hi`=0 and `a9_hv`=1. The output depends on `addr`:
  - `addr`=0 returns 8'hBF.
  - `addr`=1 returns parameter `DEV_ID`.
  - Any address with a bit above bit 0 set returns 8'h00.
- R5: Erase mode (code 4) applies when `ce_n`=0, `oe_n`=1, `vpp_hi`=1 and `a9_hv`=1. A strobe pulse that is accepted in this mode sets every byte to 8'hFF.
- R6: Program mode (code 3) applies when `ce_n`=0, `oe_n`=1, `vpp_hi`=1 and `a9_hv`=0. An accepted pulse writes old AND `din` into the addressed byte.
- R7: A pulse is accepted on the `PULSE_CYC`-th consecutive rising edge that samples `pgm_n`=0, counting from the edge that saw the falling edge. The pulse aborts with the array unchanged in either of these cases:
  - the strobe rises before that edge, or
  - the mode changes before that edge.
- R8: With `ce_n`=1 and `vpp_hi`=1, the mode is inhibit (code 5). The bus is not driven and strobe pulses change nothing.
- R9: With `ce_n`=0 and `oe_n`=1 and no supply raised, the mode is output disable (code 2). The same code applies with `ce_n`=0, `oe_n`=0 and `vpp_hi`=1. In both cases the bus is undriven.
- R10: A pulse starts only on a falling edge that is seen while the block is in program or erase mode. If the strobe is already low when the block enters program mode, holding it low writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset; the array resets to all 8'hFF |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output gate |
| pgm_n | input | 1 | Active-low program/erase strobe |
| vpp_hi | input | 1 | Programming supply raised |
| a9_hv | input | 1 | Supervoltage on address line 9 |
| addr | input | AW | Byte address |
| din | input | 8 | Byte to program |
| dq_out | output | 8 | Read or identifier byte; 8'h00 when undriven |
| dq_oe | output | 1 | Data bus drive enable |
| mode_o | output | 3 | Decoded mode code |

## Verification
The hardest situations to reach from the ports are the partial pulses, because the strobe must be timed to the edge. A strobe that is released one edge short must leave the array unchanged. A pulse that is started correctly but cut off by a change of mode must also leave the array unchanged. The stimulus places the falling edge after a settling edge in the target mode, then counts rising edges exactly: `PULSE_CYC`-1 edges to abort and `PULSE_CYC` edges to commit. The bench also drops the strobe while the block is in inhibit mode and then enters program mode with the strobe still low. This shows that a level without a visible falling edge never writes.

// File: rtl/mtp_pkg.sv
package mtp_pkg;
  typedef enum logic [2:0] {
    MD_STANDBY = 3'd0,
    MD_READ    = 3'd1,
    MD_OUTDIS  = 3'd2,
    MD_PROGRAM = 3'd3,
    MD_ERASE   = 3'd4,
    MD_INHIBIT = 3'd5,
    MD_IDENT   = 3'd6
  } mode_e;

  localparam logic [7:0] MFR_CODE = 8'hBF;
  localparam logic [7:0] ERASED   = 8'hFF;
endpackage

// File: rtl/mtp_mode_decode.sv
module mtp_mode_decode
  import mtp_pkg::*;
(
  input  logic  ce_n,
  input  logic  oe_n,
  input  logic  vpp_hi,
  input  logic  a9_hv,
  output mode_e mode
);
  always_comb begin
    if (ce_n) begin
      mode = vpp_hi ? MD_INHIBIT : MD_STANDBY;
    end else if (vpp_hi) begin
      if (oe_n) mode = a9_hv ? MD_ERASE : MD_PROGRAM;
      else      mode = MD_OUTDIS;
    end else begin
      if (oe_n) mode = MD_OUTDIS;
      else      mode = a9_hv ? MD_IDENT : MD_READ;
    end
  end
endmodule

// File: rtl/mtp_strobe_timer.sv
module mtp_strobe_timer
  import mtp_pkg::*;
#(
  parameter int PULSE_CYC = 6
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pgm_n,
  input  mode_e mode,
  output logic  fire_prog,
  output logic  fire_erase
);
  localparam int CW = $clog2(PULSE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(PULSE_CYC - 1);

  logic          strobe_q;
  logic          busy;
  logic [CW-1:0] cnt;
  mode_e         op_q;
  logic          start, hold_ok, done_now;
  mode_e         kind;

  assign start   = strobe_q & ~pgm_n & ((mode == MD_PROGRAM) | (mode == MD_ERASE));
  assign hold_ok = busy & ~pgm_n & (mode == op_q);

  generate
    if (PULSE_CYC == 1) begin : g_single
      assign done_now = start & ~busy;
    end else begin : g_multi
      assign done_now = hold_ok & (cnt == LAST);
    end
  endgenerate

  assign kind       = busy ? op_q : mode;
  assign fire_prog  = done_now & (kind == MD_PROGRAM);
  assign fire_erase = done_now & (kind == MD_ERASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b1;
      busy     <= 1'b0;
      cnt      <= '0;
      op_q     <= MD_STANDBY;
    end else begin
      strobe_q <= pgm_n;
      if (!busy) begin
        if (start && !done_now) begin
          busy <= 1'b1;
          cnt  <= CW'(1);
          op_q <= mode;
        end
      end else if (!hold_ok || done_now) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/mtp_cell_array.sv
module mtp_cell_array
  import mtp_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  input  logic          fire_prog,
  input  logic          fire_erase,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] cells [DEPTH];

  generate
    for (genvar w = 0; w < DEPTH; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cells[w] <= ERASED;
        end else if (fire_erase) begin
          cells[w] <= ERASED;
        end else if (fire_prog && (addr == AW'(w))) begin
          cells[w] <= cells[w] & din;
        end
      end
    end
  endgenerate

  assign rdata = cells[addr];
endmodule

// File: rtl/mtp_mem_ctrl.sv
module mtp_mem_ctrl
  import mtp_pkg::*;
#(
  parameter int         AW        = 8,
  parameter int         PULSE_CYC = 6,
  parameter logic [7:0] DEV_ID    = 8'hA5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          pgm_n,
  input  logic          vpp_hi,
  input  logic          a9_hv,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic [7:0]    dq_out,
  output logic          dq_oe,
  output logic [2:0]    mode_o
);
  mode_e      mode;
  logic       fire_prog, fire_erase;
  logic [7:0] rdata;
  logic [7:0] id_byte;

  mtp_mode_decode u_dec (
    .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi), .a9_hv(a9_hv), .mode(mode)
  );

  mtp_strobe_timer #(.PULSE_CYC(PULSE_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .pgm_n(pgm_n), .mode(mode),
    .fire_prog(fire_prog), .fire_erase(fire_erase)
  );

  mtp_cell_array #(.AW(AW)) u_arr (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
    .fire_prog(fire_prog), .fire_erase(fire_erase), .rdata(rdata)
  );

  generate
    if (AW > 1) begin : g_idw
      assign id_byte = (addr[AW-1:1] != '0) ? 8'h00 : (addr[0] ? DEV_ID : MFR_CODE);
    end else begin : g_idn
      assign id_byte = addr[0] ? DEV_ID : MFR_CODE;
    end
  endgenerate

  always_comb begin
    dq_oe  = 1'b0;
    dq_out = 8'h00;
    if (mode == MD_READ) begin
      dq_oe  = 1'b1;
      dq_out = rdata;
    end else if (mode == MD_IDENT) begin
      dq_oe  = 1'b1;
      dq_out = id_byte;
    end
  end

  assign mode_o = mode;
endmodule

// File: rtl/mtp_mem_ctrl_chk.sv
module mtp_mem_ctrl_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic          vpp_hi,
  input logic [AW-1:0] addr,
  input logic [7:0]    din,
  input logic [7:0]    dq_out,
  input logic          dq_oe,
  input logic [2:0]    mode_o,
  input logic          fire_prog,
  input logic          fire_erase,
  input logic [7:0]    rdata
);
  a_r1_no_drive_when_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n) |-> !dq_oe);

  a_r2_standby: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && !vpp_hi) |-> (mode_o == 3'd0));

  a_r4_mfr_code: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd6 && addr == '0) |-> (dq_out == 8'hBF));

  a_r5_erase_all: assert property (@(posedge clk) disable iff (!rst_n)
    fire_erase |=> (rdata == 8'hFF));

  a_r6_and_only: assert property (@(posedge clk) disable iff (!rst_n)
    fire_prog ##1 $stable(addr) |-> (rdata == ($past(rdata) & $past(din))));

  a_r7_no_change_without_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire_prog && !fire_erase) ##1 $stable(addr) |-> $stable(rdata));

  a_r8_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && vpp_hi) |-> (mode_o == 3'd5 && !fire_prog && !fire_erase && !dq_oe));

  a_r7_single_op: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fire_prog, fire_erase}));
endmodule

bind mtp_mem_ctrl mtp_mem_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
  .addr(addr), .din(din), .dq_out(dq_out), .dq_oe(dq_oe), .mode_o(mode_o),
  .fire_prog(fire_prog), .fire_erase(fire_erase), .rdata(rdata)
);

// File: tb/mtp_mem_ctrl_bench.sv
`timescale 1ns/1ps
module mtp_mem_ctrl_bench;
  localparam int         AW = 8;
  localparam int         PC = 4;
  localparam logic [7:0] ID = 8'hA5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1, vpp_hi = 1'b0, a9_hv = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = 8'h00;
  logic [7:0]    dq_out;
  logic          dq_oe;
  logic [2:0]    mode_o;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mtp_mem_ctrl #(.AW(AW), .PULSE_CYC(PC), .DEV_ID(ID)) u_mtp_mem_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
    .vpp_hi(vpp_hi), .a9_hv(a9_hv), .addr(addr), .din(din),
    .dq_out(dq_out), .dq_oe(dq_oe), .mode_o(mode_o)
  );

  typedef struct {
    int         req;
    logic [2:0] mode;
    logic       oe;
    logic [7:0] data;
  } exp_t;

  exp_t sb_q[$];
  event sample_ev;

  // monitor: pops the oldest expectation and compares with the ports
  initial begin
    forever begin
      @(sample_ev);
      if (sb_q.size() != 0) begin
        exp_t e;
        e = sb_q.pop_front();
        tests++;
        if (dq_out !== e.data || dq_oe !== e.oe || mode_o !== e.mode) begin
          fails++;
          $display("FAIL R%0d: actual mode=%0d oe=%0b data=%h expected mode=%0d oe=%0b data=%h",
                   e.req, mode_o, dq_oe, dq_out, e.mode, e.oe, e.data);
        end
      end
    end
  end

  task automatic pins(input logic c, input logic o, input logic v, input logic h,
                      input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    ce_n = c; oe_n = o; vpp_hi = v; a9_hv = h; addr = a; din = d;
  endtask

  task automatic expect_now(input int req, input logic [2:0] m, input logic oe,
                            input logic [7:0] d);
    exp_t e;
    e.req = req; e.mode = m; e.oe = oe; e.data = d;
    #4;
    sb_q.push_back(e);
    ->sample_ev;
    #1;
  endtask

  task automatic read_chk(input int req, input logic [AW-1:0] a, input logic [7:0] d);
    pins(1'b0, 1'b0, 1'b0, 1'b0, a, 8'h00);
    expect_now(req, 3'd1, 1'b1, d);
  endtask

  // strobe low for n rising edges, then release
  task automatic strobe(input int n);
    @(posedge clk);
    @(negedge clk);
    pgm_n = 1'b0;
    repeat (n) @(posedge clk);
    @(negedge clk);
    pgm_n = 1'b1;
    @(posedge clk);
  endtask

  task automatic program_byte(input logic [AW-1:0] a, input logic [7:0] d, input int n);
    pins(1'b0, 1'b1, 1'b1, 1'b0, a, d);
    strobe(n);
  endtask

  task automatic erase_chip(input int n);
    pins(1'b0, 1'b1, 1'b1, 1'b1, '0, 8'h00);
    strobe(n);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL R7: actual=watchdog timeout expected=run complete");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R3: reset state reads erased
    read_chk(3, 8'd0, 8'hFF);
    read_chk(3, 8'd255, 8'hFF);

    // R2: standby regardless of oe_n, strobe and a9
    pins(1'b1, 1'b0, 1'b0, 1'b1, 8'd0, 8'h00);
    pgm_n = 1'b0;
    expect_now(2, 3'd0, 1'b0, 8'h00);
    pgm_n = 1'b1;

    // R1/R9: output disable without supply
    pins(1'b0, 1'b1, 1'b0, 1'b0, 8'd0, 8'h00);
    expect_now(1, 3'd2, 1'b0, 8'h00);
    // R9: supply raised with oe_n low
    pins(1'b0, 1'b0, 1'b1, 1'b0, 8'd0, 8'h00);
    expect_now(9, 3'd2, 1'b0, 8'h00);

    // R4: identifier readout
    pins(1'b0, 1'b0, 1'b0, 1'b1, 8'd0, 8'h00);
    expect_now(4, 3'd6, 1'b1, 8'hBF);
    pins(1'b0, 1'b0, 1'b0, 1'b1, 8'd1, 8'h00);
    expect_now(4, 3'd6, 1'b1, ID);
    pins(1'b0, 1'b0, 1'b0, 1'b1, 8'd3, 8'h00);
    expect_now(4, 3'd6, 1'b1, 8'h00);

    // R6: program mode code and AND-only writes
    pins(1'b0, 1'b1, 1'b1, 1'b0, 8'd5, 8'h3C);
    expect_now(6, 3'd3, 1'b0, 8'h00);
    program_byte(8'd5, 8'h3C, PC);
    read_chk(6, 8'd5, 8'h3C);
    program_byte(8'd5, 8'hF0, PC);
    read_chk(6, 8'd5, 8'h30);
    program_byte(8'd5, 8'hFF, PC);
    read_chk(6, 8'd5, 8'h30);
    read_chk(6, 8'd4, 8'hFF);

    // R7: strobe released one edge early
    program_byte(8'd6, 8'h00, PC - 1);
    read_chk(7, 8'd6, 8'hFF);
    // R7: mode changes mid-pulse (oe_n drops)
    pins(1'b0, 1'b1, 1'b1, 1'b0, 8'd6, 8'h00);
    @(posedge clk);
    @(negedge clk);
    pgm_n = 1'b0;
    repeat (PC - 2) @(posedge clk);
    @(negedge clk);
    oe_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    pgm_n = 1'b1;
    read_chk(7, 8'd6, 8'hFF);

    // R8: inhibit with strobe pulse
    pins(1'b1, 1'b1, 1'b1, 1'b0, 8'd8, 8'h00);
    expect_now(8, 3'd5, 1'b0, 8'h00);
    strobe(PC + 2);
    read_chk(8, 8'd8, 8'hFF);

    // R10: strobe already low on entry to program mode
    pins(1'b1, 1'b1, 1'b1, 1'b0, 8'd7, 8'h00);
    pgm_n = 1'b0;
    repeat (2) @(posedge clk);
    pins(1'b0, 1'b1, 1'b1, 1'b0, 8'd7, 8'h00);
    repeat (PC + 3) @(posedge clk);
    @(negedge clk);
    pgm_n = 1'b1;
    read_chk(10, 8'd7, 8'hFF);

    // R5: erase, first aborted then complete
    program_byte(8'd9, 8'h00, PC);
    read_chk(6, 8'd9, 8'h00);
    pins(1'b0, 1'b1, 1'b1, 1'b1, 8'd0, 8'h00);
    expect_now(5, 3'd4, 1'b0, 8'h00);
    erase_chip(PC - 1);
    read_chk(7, 8'd9, 8'h00);
    erase_chip(PC);
    read_chk(5, 8'd9, 8'hFF);
    read_chk(5, 8'd5, 8'hFF);

    repeat (2) @(posedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule